// File: doc/BRIEF.md
# Programmable Interval Timer Channel

One down-counting channel of an interval timer. A separate register block hands it a write strobe together with a 3-bit mode code, a binary/decimal select and a 16-bit initial count. The channel turns these into an output waveform. The shape of that waveform depends on the mode and on a gate input. The live counter value is driven out so that the register block can latch it. A pending-load flag tells that block whether the written count has reached the counter yet. Three copies of this channel, sharing a register front end, make a full timer.

Six behaviours are provided:
- terminal-count flag
- gate-retriggered one-shot
- divide-by-n rate pulse
- divide-by-n square wave
- software-started strobe
- gate-started strobe

The counter counts either in 16-bit binary or in four BCD digits. An initial count of zero stands for the largest count. Mode codes 6 and 7 act exactly as codes 2 and 3.

Top module: `pit_channel`

## Requirements
- R1: After reset, out_o is 1, count_o is 0 and null_count_o is 0.
- R2: Bit 2 of mode_i is ignored when bit 1 is set, so code 6 gives the code-2 waveform and code 7 gives the code-3 waveform.
- R3: A load_i pulse sets null_count_o. The flag clears on the clock edge that moves the stored count into the counter. In modes 0, 2, 3 and 4 that is the next edge. In modes 1 and 5 it is the first edge with a gate rising edge.
- R4: Mode 0 drives out_o low at the load edge. The count N enters on the next edge and then falls by one per enabled clock. out_o rises on the edge where the counter reaches 0, N+1 edges after load, and stays high until the next load.
- R5: Mode 1 keeps out_o high until a gate rising edge. That edge loads N and drives out_o low, and out_o returns high when the counter reaches 0. A new gate rising edge while low reloads N and keeps out_o low.
- R6: Mode 2 gives a period of N clocks. out_o goes low for exactly one clock while the counter holds 1. The next edge reloads N and sets out_o high.
- R7: Mode 3 toggles out_o. The high phase lasts ceil(N/2) clocks and the low phase floor(N/2) clocks, starting high, and the counter steps by two.
- R8: Mode 4 counts from the edge after load. out_o is low for one clock when the counter reaches 0, and no further strobe follows until the next load.
- R9: Mode 5 waits for a gate rising edge, then counts N. It gives a single one-clock low strobe at 0, and the next gate rising edge repeats the cycle.
- R10: In modes 0, 2, 3 and 4, gate_i low freezes the counter, and counting resumes when gate_i returns high. Modes 1 and 5 count regardless of gate level.
- R11: With bcd_i=1 every nibble of the count is a decimal digit 0..9 (the initial count must be valid BCD), and 0 steps down to 0x9999. In binary, 0 steps down to 0xFFFF. An initial count of 0 thus spans 10000 or 65536 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | One-clock write strobe for mode, select and count |
| mode_i | input | 3 | Mode code, sampled with load_i |
| bcd_i | input | 1 | 1 selects 4-digit BCD counting, sampled with load_i |
| count_i | input | 16 | Initial count, sampled with load_i |
| gate_i | input | 1 | Gate: level enable or rising-edge trigger depending on mode |
| out_o | output | 1 | Timer output waveform |
| count_o | output | 16 | Live counter value, for latching by the register block |
| null_count_o | output | 1 | Written count not yet moved into the counter |

## Verification
All results are registered. out_o and null_count_o change on the load edge itself. The counter takes the new count one edge later, or on the gate-trigger edge in the triggered modes. Each following edge moves count_o and out_o by one step. The bench drives inputs and samples outputs on the falling clock edge, and it counts edges from the load edge, so it knows which sample must show each change. It then compares out_o and count_o against the expected value for every edge through at least one full period.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int CNT_W  = 16;
  localparam int DIGITS = CNT_W / 4;

  typedef enum logic [2:0] {
    M_TC_INT    = 3'd0,
    M_ONESHOT   = 3'd1,
    M_RATE      = 3'd2,
    M_SQUARE    = 3'd3,
    M_SW_STROBE = 3'd4,
    M_HW_STROBE = 3'd5
  } mode_e;

  // codes 6/7 fold onto 2/3
  function automatic mode_e decode_mode(input logic [2:0] code);
    if (code[1]) return mode_e'({1'b0, code[1:0]});
    return mode_e'(code);
  endfunction

  function automatic logic [CNT_W-1:0] step_val(input logic [CNT_W-1:0] v,
                                                input logic bcd, input logic up,
                                                input logic [1:0] amt);
    logic [CNT_W-1:0] r;
    logic [4:0] d;
    logic [4:0] c;
    r = '0;
    if (!bcd) return up ? v + CNT_W'(amt) : v - CNT_W'(amt);
    c = {3'b0, amt};
    for (int i = 0; i < DIGITS; i++) begin
      d = {1'b0, v[i*4 +: 4]};
      if (up) begin
        d = d + c;
        if (d > 5'd9) begin d = d - 5'd10; c = 5'd1; end
        else c = 5'd0;
      end else begin
        if (d >= c) begin d = d - c; c = 5'd0; end
        else begin d = d + 5'd10 - c; c = 5'd1; end
      end
      r[i*4 +: 4] = d[3:0];
    end
    return r;
  endfunction

  function automatic logic bcd_ok(input logic [CNT_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/pit_gate_edge.sv
module pit_gate_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_i;
  end

  assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/pit_cnt_step.sv
module pit_cnt_step
  import pit_pkg::*;
(
  input  logic [CNT_W-1:0] value_i,
  input  logic             bcd_i,
  output logic [CNT_W-1:0] dec1_o,
  output logic [CNT_W-1:0] dec2_o
);
  assign dec1_o = step_val(value_i, bcd_i, 1'b0, 2'd1);
  assign dec2_o = step_val(value_i, bcd_i, 1'b0, 2'd2);
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [2:0]       mode_i,
  input  logic             bcd_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             gate_i,
  output logic             out_o,
  output logic [CNT_W-1:0] count_o,
  output logic             null_count_o
);
  mode_e            mode_q;
  logic             bcd_q, out_q, null_q, pend_q, run_q, arm_q;
  logic [CNT_W-1:0] init_q, cnt_q;
  logic [CNT_W-1:0] dec1, dec2, hi_load, lo_load, start_val;
  logic             gate_rise, trig_mode, cnt_en;

  pit_gate_edge u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_i (gate_i),
    .rise_o (gate_rise)
  );

  pit_cnt_step u_step (
    .value_i (cnt_q),
    .bcd_i   (bcd_q),
    .dec1_o  (dec1),
    .dec2_o  (dec2)
  );

  assign trig_mode = (mode_q == M_ONESHOT) || (mode_q == M_HW_STROBE);
  assign cnt_en    = run_q && !pend_q && (trig_mode || gate_i);

  // odd counts: high half rounds up, low half rounds down
  assign hi_load   = init_q[0] ? step_val(init_q, bcd_q, 1'b1, 2'd1) : init_q;
  assign lo_load   = init_q[0] ? step_val(init_q, bcd_q, 1'b0, 2'd1) : init_q;
  assign start_val = (mode_q == M_SQUARE) ? hi_load : init_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_TC_INT;
      bcd_q  <= 1'b0;
      init_q <= '0;
      cnt_q  <= '0;
      out_q  <= 1'b1;
      null_q <= 1'b0;
      pend_q <= 1'b0;
      run_q  <= 1'b0;
      arm_q  <= 1'b0;
    end else if (load_i) begin
      mode_q <= decode_mode(mode_i);
      bcd_q  <= bcd_i;
      init_q <= count_i;
      null_q <= 1'b1;
      pend_q <= 1'b1;
      run_q  <= 1'b0;
      arm_q  <= 1'b0;
      out_q  <= (decode_mode(mode_i) != M_TC_INT);
    end else begin
      // single-clock low pulses end on the following edge
      if (mode_q inside {M_RATE, M_SW_STROBE, M_HW_STROBE}) out_q <= 1'b1;
      if (pend_q && !trig_mode) begin
        cnt_q  <= start_val;
        null_q <= 1'b0;
        pend_q <= 1'b0;
        run_q  <= 1'b1;
        arm_q  <= 1'b1;
      end else if (trig_mode && gate_rise) begin
        cnt_q  <= init_q;
        null_q <= 1'b0;
        pend_q <= 1'b0;
        run_q  <= 1'b1;
        arm_q  <= 1'b1;
        out_q  <= (mode_q != M_ONESHOT);
      end else if (cnt_en) begin
        unique case (mode_q)
          M_TC_INT, M_ONESHOT: begin
            cnt_q <= dec1;
            if (dec1 == '0) out_q <= 1'b1;
          end
          M_RATE: begin
            if (cnt_q == CNT_W'(1)) cnt_q <= init_q;
            else begin
              cnt_q <= dec1;
              if (dec1 == CNT_W'(1)) out_q <= 1'b0;
            end
          end
          M_SQUARE: begin
            if (cnt_q == CNT_W'(2)) begin
              out_q <= ~out_q;
              cnt_q <= out_q ? lo_load : hi_load;
            end else begin
              cnt_q <= dec2;
            end
          end
          M_SW_STROBE, M_HW_STROBE: begin
            cnt_q <= dec1;
            if (arm_q && dec1 == '0) begin
              out_q <= 1'b0;
              arm_q <= 1'b0;
            end
          end
          default: cnt_q <= cnt_q;
        endcase
      end
    end
  end

  assign out_o        = out_q;
  assign count_o      = cnt_q;
  assign null_count_o = null_q;

  // R2
  mode_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && mode_i[1] |=> !mode_q[2]);

  // R3
  null_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    null_q && !load_i && !trig_mode |=> !null_q);

  // R4
  tc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == M_TC_INT && out_q && !load_i |=> out_q);

  // R5
  oneshot_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == M_ONESHOT && gate_rise && !load_i |=> !out_q && !null_q);

  // R6
  rate_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == M_RATE && !out_q && !load_i |=> out_q);

  // R8
  strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_SW_STROBE || mode_q == M_HW_STROBE) && !out_q && !load_i |=> out_q);

  // R10
  gate_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !pend_q && !trig_mode && !gate_i && !load_i |=> $stable(cnt_q));

  // R11
  bcd_digit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcd_q && run_q |-> bcd_ok(cnt_q));
endmodule

// File: tb/pit_channel_tb.sv
module pit_channel_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WDOG_CYC   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [2:0]  mode = '0;
  logic        bcd = 1'b0;
  logic [15:0] cnt_in = '0;
  logic        gate = 1'b0;
  logic        out;
  logic [15:0] cnt_out;
  logic        nullc;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pit_channel dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .load_i       (load),
    .mode_i       (mode),
    .bcd_i        (bcd),
    .count_i      (cnt_in),
    .gate_i       (gate),
    .out_o        (out),
    .count_o      (cnt_out),
    .null_count_o (nullc)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // returns just after the load edge
  task automatic do_load(input logic [2:0] m, input logic b, input logic [15:0] n);
    mode = m; bcd = b; cnt_in = n; load = 1'b1;
    tick(1);
    load = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 out", out, 1); chk("R1 count", cnt_out, 0); chk("R1 null", nullc, 0);
  endtask

  task automatic t_mode0();
    gate = 1'b1;
    do_load(3'd0, 1'b0, 16'd3);
    chk("R4 out at load", out, 0); chk("R3 null set", nullc, 1);
    tick(1); chk("R4 count", cnt_out, 3); chk("R3 null clear", nullc, 0); chk("R4 out", out, 0);
    tick(2); chk("R4 count", cnt_out, 1); chk("R4 out before tc", out, 0);
    tick(1); chk("R4 count", cnt_out, 0); chk("R4 out at tc", out, 1);
    tick(2); chk("R4 out held", out, 1); chk("R11 binary wrap", cnt_out, 16'hFFFE);
  endtask

  task automatic t_gate();
    gate = 1'b1;
    do_load(3'd0, 1'b0, 16'd5);
    tick(2); chk("R10 count", cnt_out, 4);
    gate = 1'b0;
    tick(2); chk("R10 frozen", cnt_out, 4);
    gate = 1'b1;
    tick(1); chk("R10 resumed", cnt_out, 3);
  endtask

  task automatic t_mode1();
    gate = 1'b0;
    do_load(3'd1, 1'b0, 16'd3);
    chk("R5 out idle", out, 1); chk("R3 null set", nullc, 1);
    tick(2); chk("R3 null waits trigger", nullc, 1); chk("R5 out idle", out, 1);
    gate = 1'b1;
    tick(1); chk("R5 count at trigger", cnt_out, 3); chk("R5 out low", out, 0); chk("R3 null clear", nullc, 0);
    tick(2); chk("R5 count", cnt_out, 1); chk("R5 out low", out, 0);
    tick(1); chk("R5 out end", out, 1);
    gate = 1'b0; tick(1);
    gate = 1'b1; tick(1); chk("R5 retrig count", cnt_out, 3); chk("R5 out low", out, 0);
    tick(1); chk("R5 count", cnt_out, 2);
    gate = 1'b0; tick(1); chk("R5 count gate low", cnt_out, 1); chk("R5 out low", out, 0);
    gate = 1'b1; tick(1); chk("R5 reload", cnt_out, 3); chk("R5 extended low", out, 0);
    tick(2); chk("R5 out still low", out, 0);
    tick(1); chk("R5 out end", out, 1);
  endtask

  task automatic t_rate(input logic [2:0] code);
    logic [7:0] pat;
    pat = 8'b0111_0111; // bit i = out after edge i+1
    gate = 1'b1;
    do_load(code, 1'b0, 16'd4);
    chk("R6 out at load", out, 1);
    for (int i = 0; i < 8; i++) begin
      tick(1);
      chk((code == 3'd6) ? "R2 alias rate out" : "R6 rate out", out, pat[i]);
      if (i == 4) chk("R6 reload", cnt_out, 4);
    end
  endtask

  task automatic t_square(input logic [2:0] code, input logic b, input logic [15:0] n,
                          input logic [15:0] pat, input int len);
    gate = 1'b1;
    do_load(code, b, n);
    chk("R7 out at load", out, 1);
    for (int i = 0; i < len; i++) begin
      tick(1);
      chk((code == 3'd7) ? "R2 alias square out" : "R7 square out", out, pat[i]);
    end
  endtask

  task automatic t_mode4();
    gate = 1'b1;
    do_load(3'd4, 1'b0, 16'd3);
    chk("R8 out at load", out, 1); chk("R3 null set", nullc, 1);
    tick(1); chk("R8 count", cnt_out, 3); chk("R3 null clear", nullc, 0);
    tick(2); chk("R8 out", out, 1);
    tick(1); chk("R8 count zero", cnt_out, 0); chk("R8 strobe", out, 0);
    tick(1); chk("R8 strobe end", out, 1);
    tick(3); chk("R8 single strobe", out, 1);
  endtask

  task automatic t_mode5();
    gate = 1'b0;
    do_load(3'd5, 1'b0, 16'd2);
    tick(1); chk("R9 waiting", out, 1); chk("R9 null waits", nullc, 1);
    gate = 1'b1;
    tick(1); chk("R9 count at trigger", cnt_out, 2); chk("R9 out", out, 1);
    tick(1); chk("R9 count", cnt_out, 1);
    tick(1); chk("R9 strobe", out, 0);
    tick(1); chk("R9 strobe end", out, 1);
    tick(2); chk("R9 no repeat", out, 1);
    gate = 1'b0; tick(1);
    gate = 1'b1; tick(1); chk("R9 retrigger", cnt_out, 2);
    tick(2); chk("R9 second strobe", out, 0);
    tick(1); chk("R9 strobe end", out, 1);
  endtask

  task automatic t_bcd();
    gate = 1'b1;
    do_load(3'd0, 1'b1, 16'h0000);
    tick(1); chk("R11 bcd zero", cnt_out, 0);
    tick(1); chk("R11 bcd wrap", cnt_out, 16'h9999); chk("R11 out low", out, 0);
    do_load(3'd0, 1'b1, 16'h0100);
    tick(1); chk("R11 bcd load", cnt_out, 16'h0100);
    tick(1); chk("R11 bcd borrow", cnt_out, 16'h0099);
    do_load(3'd0, 1'b0, 16'h0000);
    tick(2); chk("R11 binary max", cnt_out, 16'hFFFF);
  endtask

  initial begin
    tick(2);
    t_reset();
    rst_n = 1'b1;
    tick(1);
    t_mode0();
    t_gate();
    t_mode1();
    t_rate(3'd2);
    t_rate(3'd6);
    t_square(3'd3, 1'b0, 16'd4, 16'b0011_0011, 8);
    t_square(3'd7, 1'b0, 16'd4, 16'b0011_0011, 8);
    t_square(3'd3, 1'b0, 16'd5, 16'b00_1110_0111, 10);
    t_square(3'd3, 1'b1, 16'h0005, 16'b00_1110_0111, 10);
    t_mode4();
    t_mode5();
    t_bcd();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule